// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block keeps wall-clock time as a 32-bit count of seconds. A 32.768 kHz reference arrives as a one-cycle enable pulse on `ref_tick`, synchronous to the system clock. A programmable prescaler counts these pulses and produces one internal tick per second. Each tick advances the seconds counter. A second 32-bit register holds an alarm time. When a tick brings the counter to that time, a sticky event flag is raised.

A second sticky flag records every tick. Each flag has its own enable bit. The two interrupt outputs are level signals, each the AND of one flag and its enable. The prescaler's reload value shares one configuration register with a trim field. Every 1024th second is shortened by the trim amount, which corrects for crystal error. A configuration register that is entirely zero stands for "not yet set up", and the prescaler then falls back to the nominal 32768-pulse second.

Software reaches the four registers through a flat interface: a 2-bit address, a write strobe, 32-bit write data and a combinational read port.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset, all four registers read as zero and both interrupt outputs are low.
- R2: While the configuration register (address 3) is non-zero, its bits 15:0 hold a value D, and a tick occurs once every D+1 `ref_tick` pulses.
- R3: While the configuration register is all zero, a tick occurs once every 32768 `ref_tick` pulses.
- R4: Configuration bits 25:16 hold a trim amount T. Every 1024th tick period ends T pulses early, but never lasts less than one pulse. Writing the configuration register restarts both the prescaler and the 1024-tick sequence, and that write cycle produces no tick.
- R5: The seconds counter (address 0) can be read and written, and each tick adds one to it. A write in the same cycle as a tick loads the written value, and that tick is lost.
- R6: The alarm flag is status bit 0. It is set by a tick that makes the counter equal to the alarm register (address 1). A software write that makes the counter equal to the alarm register does not set it.
- R7: The tick flag is status bit 1, and every tick sets it.
- R8: In the status register (address 2), bit 2 (alarm enable) and bit 3 (tick enable) are plain read/write bits. Writing 1 to bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. A set and a clear of the same flag in the same cycle leave the flag set.
- R9: `irq_alarm` equals alarm flag AND alarm enable, and `irq_tick` equals tick flag AND tick enable, as levels.
- R10: The configuration register reads back bits 25:0 as written, and bits 31:26 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse at the 32.768 kHz reference rate |
| reg_addr | input | 2 | Register select: 0 counter, 1 alarm, 2 status, 3 configuration |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_alarm | output | 1 | Alarm interrupt level |
| irq_tick | output | 1 | Per-second interrupt level |

## Verification
The assertions assume that `ref_tick` is a clean one-cycle enable, sampled at the clock, and that a write touches only the register named by `reg_addr`. They also assume that the counter and the alarm register are not written in the same cycle that a match is being judged. The stimulus keeps `ref_tick` low around every register write, except in the directed cycles that deliberately line a write up with a tick. Random divider values are kept small enough that the 1024-tick trim slot is reached only in the directed trim cases, where the bench computes the expected tick count over the whole sequence.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // register map; bit positions in status are decoded by software
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_ALARM  = 2'd1,
    REG_STATUS = 2'd2,
    REG_CFG    = 2'd3
  } rtc_reg_e;

  localparam int EV_ALARM  = 0;
  localparam int EV_TICK   = 1;
  localparam int N_EVENTS  = 2;
  localparam int EN_OFFSET = 2;   // enable bit sits this far above its flag
  localparam int STATUS_W  = N_EVENTS + EN_OFFSET;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W       = 16,
  parameter int TRIM_W      = 10,
  parameter int TRIM_LSB    = 16,
  parameter int SLOT_LG2    = 10,
  parameter int DEFAULT_DIV = 32767,
  localparam int CFG_W      = TRIM_LSB + TRIM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_value,
  output logic [CFG_W-1:0] cfg_o,
  output logic             tick_o
);

  localparam logic [DIV_W-1:0] DEF_END = DIV_W'(DEFAULT_DIV);

  logic [CFG_W-1:0]    cfg_q;
  logic [DIV_W-1:0]    presc_q;
  logic [SLOT_LG2-1:0] slot_q;
  logic [DIV_W-1:0]    end_cur;
  logic                slot_last;

  // last count of the current period; shortened in the trim slot
  function automatic logic [DIV_W-1:0] period_end(input logic [CFG_W-1:0] cfg,
                                                  input logic short_slot);
    logic [DIV_W-1:0] base;
    logic [DIV_W-1:0] cut;
    base = (cfg == '0) ? DEF_END : cfg[DIV_W-1:0];
    cut  = DIV_W'(cfg[TRIM_LSB +: TRIM_W]);
    if (!short_slot) return base;
    return (base > cut) ? base - cut : '0;
  endfunction

  assign slot_last = &slot_q;
  assign end_cur   = period_end(cfg_q, slot_last);
  assign tick_o    = ref_tick && !cfg_load && (presc_q >= end_cur);
  assign cfg_o     = cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      presc_q <= '0;
      slot_q  <= '0;
    end else if (cfg_load) begin
      cfg_q   <= cfg_value;
      presc_q <= '0;
      slot_q  <= '0;
    end else if (ref_tick) begin
      if (tick_o) begin
        presc_q <= '0;
        slot_q  <= slot_q + 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  // R2
  presc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= end_cur);

  // R4
  cfg_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (presc_q == '0) && (slot_q == '0) && (cfg_q == $past(cfg_value)));

  // R2
  tick_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> ref_tick);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !cfg_load) |=> $stable(presc_q) && $stable(slot_q));

endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic             alm_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] alarm_o,
  output logic             alarm_hit_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] alarm_q;
  logic [CNT_W-1:0] count_inc;
  logic             tick_taken;

  function automatic logic [CNT_W-1:0] next_second(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  assign tick_taken  = tick && !cnt_we;
  assign count_inc   = next_second(count_q);
  assign alarm_hit_o = tick_taken && (count_inc == alarm_q);
  assign count_o     = count_q;
  assign alarm_o     = alarm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      alarm_q <= '0;
    end else begin
      if (cnt_we)          count_q <= wdata;
      else if (tick_taken) count_q <= count_inc;
      if (alm_we)          alarm_q <= wdata;
    end
  end

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we) |=> count_q == $past(count_q) + CNT_W'(1));

  // R5
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count_q == $past(wdata));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(count_q));

  // R6
  alarm_meets_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit_o && !alm_we) |=> count_q == alarm_q);

endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags
  import rtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_EVENTS-1:0] ev_set,
  input  logic                st_we,
  input  logic [STATUS_W-1:0] st_wdata,
  output logic [STATUS_W-1:0] status_o,
  output logic [N_EVENTS-1:0] irq_o
);

  logic [N_EVENTS-1:0] flag_q;
  logic [N_EVENTS-1:0] en_q;
  logic [N_EVENTS-1:0] clr_req;

  assign clr_req  = st_we ? st_wdata[N_EVENTS-1:0] : '0;
  assign status_o = {en_q, flag_q};

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (st_we) en_q <= st_wdata[EN_OFFSET +: N_EVENTS];
  end

  for (genvar i = 0; i < N_EVENTS; i++) begin : g_ev
    always_ff @(posedge clk) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (ev_set[i])  flag_q[i] <= 1'b1;
      else if (clr_req[i]) flag_q[i] <= 1'b0;
    end

    assign irq_o[i] = flag_q[i] & en_q[i];

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_set[i] |=> flag_q[i]);

    // R8
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && st_wdata[i] && !ev_set[i]) |=> !flag_q[i]);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_set[i] && !(st_we && st_wdata[i])) |=> $stable(flag_q[i]));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[i]) |-> $past(ev_set[i] || st_we));
  end

endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DIV_W       = 16,
  parameter int TRIM_W      = 10,
  parameter int TRIM_LSB    = 16,
  parameter int SLOT_LG2    = 10,
  parameter int DEFAULT_DIV = 32767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_alarm,
  output logic              irq_tick
);

  localparam int CFG_W = TRIM_LSB + TRIM_W;

  rtc_reg_e            sel;
  logic                we_count, we_alarm, we_status, we_cfg;
  logic                sec_tick;
  logic                alarm_hit;
  logic [CFG_W-1:0]    cfg_val;
  logic [DATA_W-1:0]   count_val, alarm_val;
  logic [STATUS_W-1:0] status_val;
  logic [N_EVENTS-1:0] ev_set, irq_vec;

  assign sel       = rtc_reg_e'(reg_addr);
  assign we_count  = reg_we && (sel == REG_COUNT);
  assign we_alarm  = reg_we && (sel == REG_ALARM);
  assign we_status = reg_we && (sel == REG_STATUS);
  assign we_cfg    = reg_we && (sel == REG_CFG);

  rtc_prescaler #(
    .DIV_W(DIV_W), .TRIM_W(TRIM_W), .TRIM_LSB(TRIM_LSB),
    .SLOT_LG2(SLOT_LG2), .DEFAULT_DIV(DEFAULT_DIV)
  ) u_presc (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .cfg_load(we_cfg), .cfg_value(reg_wdata[CFG_W-1:0]),
    .cfg_o(cfg_val), .tick_o(sec_tick)
  );

  rtc_seconds #(.CNT_W(DATA_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick),
    .cnt_we(we_count), .alm_we(we_alarm), .wdata(reg_wdata),
    .count_o(count_val), .alarm_o(alarm_val), .alarm_hit_o(alarm_hit)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EV_ALARM] = alarm_hit;
    ev_set[EV_TICK]  = sec_tick;
  end

  rtc_event_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set),
    .st_we(we_status), .st_wdata(reg_wdata[STATUS_W-1:0]),
    .status_o(status_val), .irq_o(irq_vec)
  );

  assign irq_alarm = irq_vec[EV_ALARM];
  assign irq_tick  = irq_vec[EV_TICK];

  always_comb begin
    unique case (sel)
      REG_COUNT:  reg_rdata = count_val;
      REG_ALARM:  reg_rdata = alarm_val;
      REG_STATUS: reg_rdata = DATA_W'(status_val);
      REG_CFG:    reg_rdata = DATA_W'(cfg_val);
      default:    reg_rdata = '0;
    endcase
  end

  // R7
  tick_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> status_val[EV_TICK]);

  // R6
  alarm_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> sec_tick);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !irq_alarm && !irq_tick && (count_val == '0));

endmodule

// File: tb/tb_rtc_sec_alarm.sv
module tb_rtc_sec_alarm;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_alarm, irq_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_sec_alarm dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_alarm(irq_alarm), .irq_tick(irq_tick)
  );

  localparam logic [1:0] A_CNT = 2'd0, A_ALM = 2'd1, A_ST = 2'd2, A_CFG = 2'd3;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulses(input int n);
    repeat (n) begin
      @(negedge clk);
      ref_tick = 1'b1;
    end
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  // ticks produced by n reference pulses from a fresh restart
  function automatic int ticks_for(input int n, input int d, input int trim);
    int k = 0;
    int rem = n;
    int per;
    while (1) begin
      if ((k % 1024) == 1023) per = (trim >= d) ? 1 : d + 1 - trim;
      else                    per = d + 1;
      if (rem < per) break;
      rem -= per;
      k++;
    end
    return k;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    process::self().srandom(32'h5eed_1234);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 irq_alarm", {31'b0, irq_alarm}, 32'h0);
    check("R1 irq_tick", {31'b0, irq_tick}, 32'h0);

    // R3 default period with all-zero configuration
    pulses(32767);
    rd(A_CNT, v); check("R3 no tick before 32768", v, 32'd0);
    rd(A_ST, v);  check("R7 tick flag clear before tick", v, 32'h0);
    pulses(1);
    rd(A_CNT, v); check("R3 tick at 32768", v, 32'd1);
    rd(A_ST, v);  check("R7 tick flag set", v & 32'h2, 32'h2);

    // R10 configuration readback
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, v); check("R10 cfg readback", v, 32'h03FF_FFFF);

    // R2 R5 R6 R7 R9 random
    for (int it = 0; it < 24; it++) begin
      int d, n, t, k;
      logic [31:0] start;
      logic [1:0] en;
      logic af, tf;
      d = int'($urandom % 15) + 1;
      n = int'($urandom % 120) + 1;
      k = int'($urandom % 10) + 1;
      start = $urandom;
      en = 2'($urandom);
      wr(A_CFG, 32'(d));
      wr(A_CNT, start);
      wr(A_ALM, start + 32'(k));
      wr(A_ST, {28'b0, en, 2'b11});
      pulses(n);
      t = n / (d + 1);
      rd(A_CNT, v); check("R2 R5 counter after ticks", v, start + 32'(t));
      af = (k <= t);
      tf = (t > 0);
      rd(A_ST, v);  check("R6 R7 R8 status", v, {28'b0, en, tf, af});
      check("R9 irq_alarm", {31'b0, irq_alarm}, {31'b0, af & en[0]});
      check("R9 irq_tick", {31'b0, irq_tick}, {31'b0, tf & en[1]});
    end

    // R4 trim slot
    wr(A_CFG, {6'b0, 10'd2, 16'd3});
    wr(A_CNT, 32'd0);
    pulses(4093);
    rd(A_CNT, v); check("R4 trim before short slot end", v, 32'(ticks_for(4093, 3, 2)));
    pulses(1);
    rd(A_CNT, v); check("R4 trim short slot", v, 32'(ticks_for(4094, 3, 2)));
    wr(A_CFG, {6'b0, 10'd9, 16'd3});
    wr(A_CNT, 32'd0);
    pulses(4093);
    rd(A_CNT, v); check("R4 trim saturates", v, 32'(ticks_for(4093, 3, 9)));

    // R4 cfg write restarts prescaler
    wr(A_CFG, 32'd3);
    wr(A_CNT, 32'd7);
    pulses(2);
    wr(A_CFG, 32'd3);
    pulses(2);
    rd(A_CNT, v); check("R4 restart no tick", v, 32'd7);
    pulses(2);
    rd(A_CNT, v); check("R4 restart tick", v, 32'd8);

    // tick per pulse for the priority cases
    wr(A_CFG, {6'b0, 10'd1, 16'd0});
    wr(A_ST, 32'h3);
    wr(A_CNT, 32'd9);
    wr(A_ALM, 32'd10);
    pulses(1);
    rd(A_ST, v); check("R6 alarm on tick match", v, 32'h3);
    wr(A_ST, 32'h2);
    rd(A_ST, v); check("R8 write1 clear, write0 keep", v, 32'h1);
    wr(A_ST, 32'h4);
    check("R9 irq_alarm enabled", {31'b0, irq_alarm}, 32'h1);
    check("R9 irq_tick off", {31'b0, irq_tick}, 32'h0);
    wr(A_ST, 32'h5);
    check("R9 irq_alarm after clear", {31'b0, irq_alarm}, 32'h0);

    // R8 set wins over clear in the same cycle
    @(negedge clk);
    reg_addr = A_ST; reg_we = 1'b1; reg_wdata = 32'h3; ref_tick = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; ref_tick = 1'b0;
    rd(A_ST, v); check("R8 set wins", v & 32'h2, 32'h2);

    // R5 write wins over tick
    @(negedge clk);
    reg_addr = A_CNT; reg_we = 1'b1; reg_wdata = 32'd100; ref_tick = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; ref_tick = 1'b0;
    rd(A_CNT, v); check("R5 write beats tick", v, 32'd100);

    // R6 software write equal to alarm does not set flag
    wr(A_ST, 32'h3);
    wr(A_ALM, 32'd50);
    wr(A_CNT, 32'd50);
    rd(A_ST, v); check("R6 no flag on write match", v, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule